// File: doc/BRIEF.md
# Timer Channel Register Front End

This block sits between an 8-bit processor bus and the counting core of a single timer channel. Software writes a configuration byte that picks three things: how the 16-bit count is carried over the bus, the counting mode, and whether counting is binary or decimal. The block then gathers one or two data bytes into a 16-bit initial value. Once the last byte that the chosen format needs has arrived, it hands that value to the core with a single-cycle load pulse.

The block also serves reads. The core's running count is offered one byte per read. In two-byte format the first read captures the whole count in a holding register, so the following high-byte read comes from the same sample. A configuration byte whose access field is zero does not change the configuration. It freezes the running count for later reads instead. A status byte is always available. It carries the core's output level, a flag that shows whether a written count is still waiting to reach the core, and the six configuration bits.

Top module: `tmr_regif`

## Requirements
- R1: After reset, status[5:0] is 0, the pending-load flag (status[6]) is 1, core_load is 0 and dout is 0.
- R2: A config write (wr_ctrl) whose bits [5:4] are not 00 stores din[5:0]. From the next cycle, status[5:0] shows din[5:0]. Bits [5:4] are the access format, [3:1] the mode and [0] the decimal flag. din[7:6] has no effect. status[7] always follows out_level.
- R3: status[6] is set by every config write and by the first byte of a two-byte count. It is cleared in the cycle in which core_load is high.
- R4: In access format 01 (low only), each wr_data gives core_load=1 in the next cycle, with core_count = {8'h00, din}.
- R5: In access format 10 (high only), each wr_data gives core_load=1 in the next cycle, with core_count = {din, 8'h00}.
- R6: In access format 11, the first wr_data is the low byte and causes no load. The second is the high byte and gives core_load=1 with core_count = {high, low}. After that, the next write is a low byte again.
- R7: A config write returns the write sequence to the low byte. It discards a half-written count and never causes a load.
- R8: In format 11, the first rd_data returns live_count[7:0] in dout in the next cycle and captures live_count. The second read returns the captured high byte, even if live_count has changed in between.
- R9: In formats 01 and 10, each rd_data returns the low or high byte of live_count respectively, unless a frozen value is pending.
- R10: A config write with bits [5:4] = 00 freezes live_count and leaves status[5:0] unchanged. Reads then return the frozen value until the format's byte sequence completes, which releases it. A second freeze command while one is pending is ignored.
- R11: A config write that changes the configuration releases a pending frozen value and returns the read sequence to the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_ctrl | input | 1 | Configuration byte write strobe |
| wr_data | input | 1 | Count byte write strobe |
| rd_data | input | 1 | Count byte read strobe |
| din | input | 8 | Bus write data |
| dout | output | 8 | Byte returned by the last read |
| status | output | 8 | {out_level, pending-load, access[1:0], mode[2:0], decimal} |
| live_count | input | 16 | Running count from the core |
| out_level | input | 1 | Output level from the core |
| core_load | output | 1 | One-cycle strobe that loads core_count into the core |
| core_count | output | 16 | Assembled initial count |
| cfg_mode | output | 3 | Stored mode field for the core |
| cfg_bcd | output | 1 | Stored decimal-counting flag for the core |

## Verification
The hardest situation to reach is a read sequence whose two bytes straddle a change of the running count, with a freeze command in between. Only then does it matter whether the high byte comes from the held sample or from the live input. The bench reaches it by changing live_count between the first and second read of each pair. It also issues a freeze, changes the live value, and sends a second freeze before reading. The configuration echo is swept over all 256 control bytes, and the load path over many byte values in each access format.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ACC_FREEZE = 2'b00,
    ACC_LO     = 2'b01,
    ACC_HI     = 2'b10,
    ACC_LOHI   = 2'b11
  } acc_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } cfg_t;
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
  import tmr_regif_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic [BYTE_W-1:0] din,
  output cfg_t        cfg,
  output logic        cfg_wr,
  output logic        freeze_cmd
);
  cfg_t cfg_d;
  logic cfg_en;
  logic unused_sel;

  assign unused_sel = ^din[BYTE_W-1:6];
  assign freeze_cmd = wr_ctrl && (din[5:4] == ACC_FREEZE);
  assign cfg_wr     = wr_ctrl && (din[5:4] != ACC_FREEZE);
  assign cfg_en     = cfg_wr;

  always_comb begin
    cfg_d      = cfg;
    cfg_d.acc  = acc_e'(din[5:4]);
    cfg_d.mode = din[3:1];
    cfg_d.bcd  = din[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_en) cfg <= cfg_d;
  end
endmodule

// File: rtl/tmr_load_seq.sv
module tmr_load_seq
  import tmr_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_e              acc,
  input  logic              cfg_wr,
  input  logic              wr_data,
  input  logic [BYTE_W-1:0] din,
  output logic              core_load,
  output logic [CNT_W-1:0]  core_count,
  output logic              pend
);
  logic              wr_hi_q, wr_hi_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              load_d, pend_d;
  logic              st_en, cnt_en;

  always_comb begin
    wr_hi_d = wr_hi_q;
    lo_d    = lo_q;
    cnt_d   = core_count;
    load_d  = 1'b0;
    pend_d  = pend;
    cnt_en  = 1'b0;
    if (cfg_wr) begin
      wr_hi_d = 1'b0;
      pend_d  = 1'b1;
    end else if (wr_data) begin
      unique case (acc)
        ACC_LO: begin
          cnt_d = {{BYTE_W{1'b0}}, din}; load_d = 1'b1; pend_d = 1'b0; cnt_en = 1'b1;
        end
        ACC_HI: begin
          cnt_d = {din, {BYTE_W{1'b0}}}; load_d = 1'b1; pend_d = 1'b0; cnt_en = 1'b1;
        end
        ACC_LOHI: begin
          if (!wr_hi_q) begin
            lo_d = din; wr_hi_d = 1'b1; pend_d = 1'b1;
          end else begin
            cnt_d = {din, lo_q}; load_d = 1'b1; pend_d = 1'b0;
            wr_hi_d = 1'b0; cnt_en = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign st_en = cfg_wr || wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_hi_q   <= 1'b0;
      lo_q      <= '0;
      pend      <= 1'b1;
      core_load <= 1'b0;
    end else begin
      core_load <= load_d;
      if (st_en) begin
        wr_hi_q <= wr_hi_d;
        lo_q    <= lo_d;
        pend    <= pend_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      core_count <= '0;
    else if (cnt_en) core_count <= cnt_d;
  end
endmodule

// File: rtl/tmr_read_path.sv
module tmr_read_path
  import tmr_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_e              acc,
  input  logic              cfg_wr,
  input  logic              freeze_cmd,
  input  logic              rd_data,
  input  logic [CNT_W-1:0]  live_count,
  output logic [BYTE_W-1:0] dout
);
  logic [CNT_W-1:0]  hold_q, hold_d, src;
  logic              held_q, held_d;
  logic              rd_hi_q, rd_hi_d;
  logic [BYTE_W-1:0] dout_d;
  logic              st_en;

  assign src = held_q ? hold_q : live_count;

  always_comb begin
    hold_d  = hold_q;
    held_d  = held_q;
    rd_hi_d = rd_hi_q;
    dout_d  = dout;
    if (cfg_wr) begin
      held_d  = 1'b0;
      rd_hi_d = 1'b0;
    end else if (freeze_cmd) begin
      if (!held_q) begin
        hold_d  = live_count;
        held_d  = 1'b1;
        rd_hi_d = 1'b0;
      end
    end else if (rd_data) begin
      unique case (acc)
        ACC_HI: begin
          dout_d = src[CNT_W-1:BYTE_W]; held_d = 1'b0;
        end
        ACC_LOHI: begin
          if (!rd_hi_q) begin
            dout_d = src[BYTE_W-1:0]; hold_d = src; held_d = 1'b1; rd_hi_d = 1'b1;
          end else begin
            dout_d = hold_q[CNT_W-1:BYTE_W]; held_d = 1'b0; rd_hi_d = 1'b0;
          end
        end
        default: begin
          dout_d = src[BYTE_W-1:0]; held_d = 1'b0;
        end
      endcase
    end
  end

  assign st_en = cfg_wr || freeze_cmd || rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      held_q  <= 1'b0;
      rd_hi_q <= 1'b0;
      dout    <= '0;
    end else if (st_en) begin
      hold_q  <= hold_d;
      held_q  <= held_d;
      rd_hi_q <= rd_hi_d;
      dout    <= dout_d;
    end
  end
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_regif_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_data,
  input  logic        rd_data,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic [7:0]  status,
  input  logic [15:0] live_count,
  input  logic        out_level,
  output logic        core_load,
  output logic [15:0] core_count,
  output logic [2:0]  cfg_mode,
  output logic        cfg_bcd
);
  cfg_t cfg;
  logic cfg_wr, freeze_cmd, pend;

  tmr_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .din(din),
    .cfg(cfg), .cfg_wr(cfg_wr), .freeze_cmd(freeze_cmd)
  );

  tmr_load_seq u_load (
    .clk(clk), .rst_n(rst_n), .acc(cfg.acc), .cfg_wr(cfg_wr),
    .wr_data(wr_data && !wr_ctrl), .din(din),
    .core_load(core_load), .core_count(core_count), .pend(pend)
  );

  tmr_read_path u_rd (
    .clk(clk), .rst_n(rst_n), .acc(cfg.acc), .cfg_wr(cfg_wr),
    .freeze_cmd(freeze_cmd), .rd_data(rd_data),
    .live_count(live_count), .dout(dout)
  );

  assign status   = {out_level, pend, cfg};
  assign cfg_mode = cfg.mode;
  assign cfg_bcd  = cfg.bcd;
endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ctrl,
  input logic       wr_data,
  input logic [7:0] din,
  input logic [7:0] status,
  input logic       core_load
);
  AST_LOAD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    core_load |-> $past(wr_data)); // R4
  AST_LOAD_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    core_load |-> !status[6]); // R3
  AST_CFG_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && din[5:4] != 2'b00) |=> (status[6] && status[5:0] == $past(din[5:0]))); // R2
  AST_FREEZE_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && din[5:4] == 2'b00) |=> $stable(status[5:0])); // R10
  AST_CFG_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !core_load); // R7
endmodule

bind tmr_regif tmr_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
  .din(din), .status(status), .core_load(core_load)
);

// File: tb/tmr_regif_test.sv
module tmr_regif_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_ctrl = 1'b0, wr_data = 1'b0, rd_data = 1'b0;
  logic [7:0]  din = '0;
  logic [7:0]  dout, status;
  logic [15:0] live_count = '0;
  logic        out_level = 1'b0;
  logic        core_load;
  logic [15:0] core_count;
  logic [2:0]  cfg_mode;
  logic        cfg_bcd;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_regif uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_ctrl(input logic [7:0] b);
    @(negedge clk); wr_ctrl = 1'b1; din = b;
    @(negedge clk); wr_ctrl = 1'b0;
  endtask
  task automatic pulse_wr(input logic [7:0] b);
    @(negedge clk); wr_data = 1'b1; din = b;
    @(negedge clk); wr_data = 1'b0;
  endtask
  task automatic pulse_rd();
    @(negedge clk); rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, exp;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(status[6:0] == 7'h40, "R1", status, 8'h40);
    chk(core_load == 1'b0, "R1", core_load, 0);
    chk(dout == 8'h00, "R1", dout, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 sweep all control bytes
    for (int c = 0; c < 256; c++) begin
      logic [5:0] prev;
      prev = status[5:0];
      out_level = c[0] ^ c[3];
      pulse_ctrl(8'(c));
      if (c[5:4] != 2'b00) begin
        chk(status[5:0] == c[5:0], "R2", status[5:0], c[5:0]);
        chk(status[6] == 1'b1, "R3", status[6], 1);
        chk(cfg_mode == c[3:1] && cfg_bcd == c[0], "R2", {cfg_mode, cfg_bcd}, c[3:0]);
      end else begin
        chk(status[5:0] == prev, "R10", status[5:0], prev);
      end
      chk(status[7] == out_level, "R2", status[7], out_level);
    end
    // R4 low only
    pulse_ctrl(8'h10);
    for (int i = 0; i < 32; i++) begin
      v = 16'(i * 37 + 5);
      pulse_wr(v[7:0]);
      chk(core_load && core_count == {8'h00, v[7:0]}, "R4", core_count, {8'h00, v[7:0]});
      chk(status[6] == 1'b0, "R3", status[6], 0);
      @(negedge clk);
      chk(!core_load, "R4", core_load, 0);
    end
    // R5 high only
    pulse_ctrl(8'h20);
    for (int i = 0; i < 32; i++) begin
      v = 16'(i * 53 + 11);
      pulse_wr(v[7:0]);
      chk(core_load && core_count == {v[7:0], 8'h00}, "R5", core_count, {v[7:0], 8'h00});
    end
    // R6 low then high
    pulse_ctrl(8'h36);
    for (int i = 0; i < 32; i++) begin
      v = 16'(i * 16'h1357 + 16'h0102);
      pulse_wr(v[7:0]);
      chk(!core_load && status[6], "R6", {core_load, status[6]}, 1);
      pulse_wr(v[15:8]);
      chk(core_load && core_count == v, "R6", core_count, v);
      chk(!status[6], "R3", status[6], 0);
    end
    // R7 control word abandons half count
    pulse_wr(8'hAA);
    pulse_ctrl(8'h36);
    chk(!core_load, "R7", core_load, 0);
    pulse_wr(8'h34);
    chk(!core_load, "R7", core_load, 0);
    pulse_wr(8'h12);
    chk(core_load && core_count == 16'h1234, "R7", core_count, 16'h1234);
    // R8 coherent two-byte reads
    for (int i = 0; i < 16; i++) begin
      v = 16'(i * 16'h0F1D + 16'h00FF);
      live_count = v;
      pulse_rd();
      chk(dout == v[7:0], "R8", dout, v[7:0]);
      live_count = ~v;
      pulse_rd();
      chk(dout == v[15:8], "R8", dout, v[15:8]);
    end
    // R10 freeze, second freeze ignored, release after sequence
    live_count = 16'hBEEF;
    pulse_ctrl(8'h00);
    live_count = 16'h1111;
    pulse_ctrl(8'h00);
    live_count = 16'h2222;
    pulse_rd();
    chk(dout == 8'hEF, "R10", dout, 8'hEF);
    pulse_rd();
    chk(dout == 8'hBE, "R10", dout, 8'hBE);
    pulse_rd();
    chk(dout == 8'h22, "R10", dout, 8'h22);
    pulse_rd();
    // R9 single-byte reads follow live count
    pulse_ctrl(8'h14);
    for (int i = 0; i < 8; i++) begin
      v = 16'(i * 16'h2345 + 7);
      live_count = v;
      pulse_rd();
      chk(dout == v[7:0], "R9", dout, v[7:0]);
    end
    pulse_ctrl(8'h24);
    for (int i = 0; i < 8; i++) begin
      v = 16'(i * 16'h3141 + 9);
      live_count = v;
      pulse_rd();
      chk(dout == v[15:8], "R9", dout, v[15:8]);
    end
    // R10 freeze in high-only format releases after one read
    live_count = 16'hC3A5;
    pulse_ctrl(8'h00);
    live_count = 16'h7E00;
    pulse_rd();
    chk(dout == 8'hC3, "R10", dout, 8'hC3);
    pulse_rd();
    chk(dout == 8'h7E, "R10", dout, 8'h7E);
    // R11 control word releases freeze and resets read pointer
    pulse_ctrl(8'h30);
    live_count = 16'h5A5A;
    pulse_rd();
    live_count = 16'h0F0F;
    pulse_ctrl(8'h00);
    live_count = 16'h9988;
    pulse_ctrl(8'h30);
    exp = 16'h9988;
    pulse_rd();
    chk(dout == exp[7:0], "R11", dout, exp[7:0]);
    live_count = 16'h4433;
    pulse_rd();
    chk(dout == exp[15:8], "R11", dout, exp[15:8]);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule